// File: doc/BRIEF.md
# Thermostat Alarm With Fault Queue

This block turns a stream of temperature conversion results into a single thermostat alarm. Each result is a 16-bit two's complement value that arrives with a one-cycle valid strobe. The block compares it against an over-temperature trip limit and a lower hysteresis limit. A small consecutive-sample counter, the fault queue, rejects noise. The alarm changes state only after a programmable run of qualifying samples.

Two behaviours can be selected. In comparator mode the alarm acts like a thermostat with hysteresis: it turns on above the trip limit and turns off below the hysteresis limit. In interrupt mode every threshold event raises a latched alarm. A register read or entry into shutdown clears it. The block then watches the trip limit and the hysteresis limit in turn. All comparisons are truncated to the active conversion resolution.

The alarm level is presented in true form. A drive-low enable for an open-drain pad follows the polarity setting.

Top module: `thermo_alarm`

## Requirements
- R1: While reset is asserted and right after it, the alarm is inactive, the run counter is empty, and with polarity 0 the drive-low enable is 0.
- R2: Only the top 9+res_sel bits of the sample and of both limits take part in the signed comparison (res_sel 0,1,2,3 gives 9,10,11,12 bits). Lower bits are ignored, so values that differ only there compare as equal.
- R3: In comparator mode, an inactive alarm turns on at the clock edge that accepts the Nth consecutive valid sample strictly above the trip limit. An active alarm turns off at the edge that accepts the Nth consecutive valid sample strictly below the hysteresis limit. N is the fault-queue depth.
- R4: In comparator mode, neither a register read nor a rising edge of shutdown changes the alarm.
- R5: In interrupt mode, with the block watching the trip limit, the Nth consecutive valid sample above the trip limit sets the alarm. The block then switches to watching the hysteresis limit.
- R6: In interrupt mode, reg_read high or a rising edge of shutdown clears the alarm on that edge. If a sample on the same edge completes a run, the alarm is set.
- R7: In interrupt mode, while watching the hysteresis limit, samples above the trip limit do not set the alarm. The Nth consecutive sample below the hysteresis limit sets it, and the block goes back to watching the trip limit.
- R8: queue_sel selects the depth N: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4, 2'b11 gives 6.
- R9: A valid sample that does not qualify, including one equal to the watched limit, empties the run counter. Cycles without samp_valid leave the counter and the alarm unchanged, and the alarm changes only on an edge with a sample, a read, shutdown or a mode change.
- R10: pin_drive_low equals alarm_active when pol_high is 0 and its inverse when pol_high is 1. alarm_active is always the true alarm state.
- R11: On the edge where a new queue_sel value is first seen, the counter empties and that edge's sample is not counted. On the edge where a new mode is first seen, the counter empties, the alarm clears and the trip limit becomes the watched limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_valid | input | 1 | One-cycle strobe marking a new conversion result |
| samp | input | 16 | Conversion result, two's complement, 1/256 degree per LSB |
| trip_lim | input | 16 | Over-temperature trip limit |
| hyst_lim | input | 16 | Hysteresis limit |
| res_sel | input | 2 | Active resolution, 9 + res_sel bits |
| queue_sel | input | 2 | Fault-queue depth select |
| mode_intr | input | 1 | 0 comparator mode, 1 interrupt mode |
| pol_high | input | 1 | 0 active-low alarm pin, 1 active-high |
| shutdown | input | 1 | Shutdown level; its rising edge clears an interrupt |
| reg_read | input | 1 | Pulses when any register is read |
| alarm_active | output | 1 | True alarm state |
| pin_drive_low | output | 1 | Open-drain pull-down enable for the alarm pin |

## Verification
The bench goes after runs that are broken by a single sample equal to a limit. A design that counted "greater or equal" would fire one run early, or fail to reset its count. It sets limits and samples that differ only below the active resolution, including negative values where truncation rounds toward minus infinity. A design that skipped masking, or shifted without sign extension, would trip where it should not. It checks that a read or shutdown clears the interrupt but leaves the comparator alarm alone, and that a clear on the same edge as a completed run loses to the run. It also checks that samples above the trip limit cannot re-raise the interrupt while the hysteresis limit is the watched one, and that changing the queue depth or the mode mid-run restarts the count.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
    localparam int SAMPLE_W = 16;
    localparam int RES_MIN  = 9;
    localparam int RSEL_W   = 2;
    localparam int QSEL_W   = 2;
    localparam int CNT_W    = 3;

    typedef struct packed {
        logic              alarm;
        logic              watch_hyst;
        logic [CNT_W-1:0]  cnt;
        logic              mode;
        logic [QSEL_W-1:0] qsel;
        logic              sd;
    } state_t;

    function automatic logic [CNT_W-1:0] run_depth(input logic [QSEL_W-1:0] sel);
        case (sel)
            2'd0:    return CNT_W'(1);
            2'd1:    return CNT_W'(2);
            2'd2:    return CNT_W'(4);
            default: return CNT_W'(6);
        endcase
    endfunction
endpackage

// File: rtl/thermo_cmp.sv
module thermo_cmp #(
    parameter int W       = 16,
    parameter int RES_MIN = 9,
    parameter int RSEL_W  = 2
) (
    input  logic [W-1:0]      samp,
    input  logic [W-1:0]      trip,
    input  logic [W-1:0]      hyst,
    input  logic [RSEL_W-1:0] res_sel,
    output logic              above,
    output logic              below
);
    localparam int NRES = 1 << RSEL_W;

    logic [NRES-1:0][W-1:0] mask_tab;
    logic [W-1:0]           mask;
    logic signed [W-1:0]    s_t, t_t, h_t;

    // one truncation mask per selectable resolution
    for (genvar g = 0; g < NRES; g++) begin : g_mask
        assign mask_tab[g] = ~((W'(1) << (W - RES_MIN - g)) - W'(1));
    end

    assign mask  = mask_tab[res_sel];
    assign s_t   = $signed(samp & mask);
    assign t_t   = $signed(trip & mask);
    assign h_t   = $signed(hyst & mask);
    assign above = s_t > t_t;
    assign below = s_t < h_t;
endmodule

// File: rtl/thermo_core.sv
module thermo_core
    import thermo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_valid,
    input  logic              above,
    input  logic              below,
    input  logic              mode_intr,
    input  logic [QSEL_W-1:0] queue_sel,
    input  logic              shutdown,
    input  logic              reg_read,
    output logic              alarm
);
    state_t           st_d, st_q;
    logic [CNT_W-1:0] depth;
    logic [CNT_W:0]   cnt_inc;
    logic             mode_chg, q_chg, sd_rise, tgt_hyst, hit;

    always_comb begin
        st_d     = st_q;
        depth    = run_depth(queue_sel);
        cnt_inc  = {1'b0, st_q.cnt} + 1'b1;
        mode_chg = mode_intr != st_q.mode;
        q_chg    = queue_sel != st_q.qsel;
        sd_rise  = shutdown & ~st_q.sd;
        tgt_hyst = mode_intr ? st_q.watch_hyst : st_q.alarm;
        hit      = tgt_hyst ? below : above;

        st_d.mode = mode_intr;
        st_d.qsel = queue_sel;
        st_d.sd   = shutdown;

        if (mode_chg) begin
            st_d.cnt        = '0;
            st_d.alarm      = 1'b0;
            st_d.watch_hyst = 1'b0;
        end else begin
            if (q_chg) begin
                st_d.cnt = '0;
            end
            if (mode_intr && (reg_read || sd_rise)) begin
                st_d.alarm = 1'b0;
            end
            if (samp_valid && !q_chg) begin
                if (hit) begin
                    if (cnt_inc >= {1'b0, depth}) begin
                        st_d.cnt = '0;
                        if (mode_intr) begin
                            st_d.alarm      = 1'b1;
                            st_d.watch_hyst = ~st_q.watch_hyst;
                        end else begin
                            st_d.alarm = ~st_q.alarm;
                        end
                    end else begin
                        st_d.cnt = cnt_inc[CNT_W-1:0];
                    end
                end else begin
                    st_d.cnt = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm = st_q.alarm;
endmodule

// File: rtl/thermo_outdrv.sv
module thermo_outdrv (
    input  logic alarm,
    input  logic pol_high,
    output logic pin_drive_low
);
    // active-low: pull the pin down while alarmed; active-high: pull down while idle
    always_comb begin
        if (pol_high) pin_drive_low = ~alarm;
        else          pin_drive_low = alarm;
    end
endmodule

// File: rtl/thermo_alarm.sv
module thermo_alarm
    import thermo_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_valid,
    input  logic [W-1:0]      samp,
    input  logic [W-1:0]      trip_lim,
    input  logic [W-1:0]      hyst_lim,
    input  logic [RSEL_W-1:0] res_sel,
    input  logic [QSEL_W-1:0] queue_sel,
    input  logic              mode_intr,
    input  logic              pol_high,
    input  logic              shutdown,
    input  logic              reg_read,
    output logic              alarm_active,
    output logic              pin_drive_low
);
    logic above, below;

    thermo_cmp #(.W(W), .RES_MIN(RES_MIN), .RSEL_W(RSEL_W)) u_cmp (
        .samp    (samp),
        .trip    (trip_lim),
        .hyst    (hyst_lim),
        .res_sel (res_sel),
        .above   (above),
        .below   (below)
    );

    thermo_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_valid (samp_valid),
        .above      (above),
        .below      (below),
        .mode_intr  (mode_intr),
        .queue_sel  (queue_sel),
        .shutdown   (shutdown),
        .reg_read   (reg_read),
        .alarm      (alarm_active)
    );

    thermo_outdrv u_out (
        .alarm         (alarm_active),
        .pol_high      (pol_high),
        .pin_drive_low (pin_drive_low)
    );
endmodule

// File: rtl/thermo_alarm_chk.sv
module thermo_alarm_chk (
    input logic clk,
    input logic rst_n,
    input logic samp_valid,
    input logic mode_intr,
    input logic shutdown,
    input logic reg_read,
    input logic alarm_active
);
    // R3 / R5 / R7: a rising alarm always comes from an accepted sample
    a_r3_rise_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_active) |-> $past(samp_valid));

    // R9: with the mode steady, the alarm moves only on a sample, read or shutdown
    a_r9_change_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(alarm_active) && ($past(mode_intr) == $past(mode_intr, 2)))
        |-> ($past(samp_valid) || $past(reg_read) || $past(shutdown)));

    // R4: comparator alarm survives entry into shutdown
    a_r4_cmp_shutdown_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_intr && $stable(mode_intr) && $rose(shutdown) && !samp_valid)
        |=> $stable(alarm_active));

    // R6: a read in interrupt mode with no sample clears the alarm
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_intr && $stable(mode_intr) && reg_read && !samp_valid)
        |=> !alarm_active);
endmodule

bind thermo_alarm thermo_alarm_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .samp_valid   (samp_valid),
    .mode_intr    (mode_intr),
    .shutdown     (shutdown),
    .reg_read     (reg_read),
    .alarm_active (alarm_active)
);

// File: tb/thermo_alarm_test.sv
`timescale 1ns/1ps
module thermo_alarm_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_valid = 1'b0;
    logic [15:0] samp = '0;
    logic [15:0] trip_lim = '0;
    logic [15:0] hyst_lim = '0;
    logic [1:0]  res_sel = '0;
    logic [1:0]  queue_sel = '0;
    logic        mode_intr = 1'b0;
    logic        pol_high = 1'b0;
    logic        shutdown = 1'b0;
    logic        reg_read = 1'b0;
    logic        alarm_active, pin_drive_low;

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1";

    // behavioural reference state
    bit m_alarm, m_watch, m_mode, m_sd;
    int m_cnt;
    int m_q;

    always #2 clk = ~clk;

    thermo_alarm uut (
        .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp(samp),
        .trip_lim(trip_lim), .hyst_lim(hyst_lim), .res_sel(res_sel),
        .queue_sel(queue_sel), .mode_intr(mode_intr), .pol_high(pol_high),
        .shutdown(shutdown), .reg_read(reg_read),
        .alarm_active(alarm_active), .pin_drive_low(pin_drive_low)
    );

    function automatic logic [15:0] deg(input int d);
        return 16'(d * 256);
    endfunction

    function automatic int trunc(input logic [15:0] v);
        int sh = 16 - (9 + int'(res_sel));
        return int'($signed(v)) >>> sh;
    endfunction

    function automatic int need(input int q);
        int tab[4] = '{1, 2, 4, 6};
        return tab[q];
    endfunction

    task automatic model_step();
        bit watch_low, hit;
        if (mode_intr != m_mode) begin
            m_cnt = 0; m_alarm = 0; m_watch = 0;
        end else begin
            bit qchg = (int'(queue_sel) != m_q);
            if (qchg) m_cnt = 0;
            if (mode_intr && (reg_read || (shutdown && !m_sd))) m_alarm = 0;
            if (samp_valid && !qchg) begin
                watch_low = mode_intr ? m_watch : m_alarm;
                hit = watch_low ? (trunc(samp) < trunc(hyst_lim))
                                : (trunc(samp) > trunc(trip_lim));
                if (hit) begin
                    m_cnt++;
                    if (m_cnt >= need(int'(queue_sel))) begin
                        m_cnt = 0;
                        if (mode_intr) begin m_alarm = 1; m_watch = !m_watch; end
                        else m_alarm = !m_alarm;
                    end
                end else m_cnt = 0;
            end
        end
        m_mode = mode_intr; m_q = int'(queue_sel); m_sd = shutdown;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_alarm = 0; m_watch = 0; m_mode = 0; m_sd = 0; m_cnt = 0; m_q = 0;
        end else begin
            model_step();
        end
        #1;
        n_cmp++;
        if (alarm_active !== m_alarm || pin_drive_low !== (pol_high ? !m_alarm : m_alarm)) begin
            n_bad++;
            $display("FAIL %s alarm=%0b pin=%0b expected alarm=%0b pin=%0b", phase,
                     alarm_active, pin_drive_low, m_alarm, pol_high ? !m_alarm : m_alarm);
        end
    end

    task automatic expect_alarm(input bit e);
        n_cmp++;
        if (alarm_active !== e) begin
            n_bad++;
            $display("FAIL %s direct alarm=%0b expected %0b", phase, alarm_active, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic smp(input logic [15:0] v, input int n);
        repeat (n) begin
            @(negedge clk); samp = v; samp_valid = 1'b1;
            @(negedge clk); samp_valid = 1'b0;
        end
    endtask

    task automatic smp_rd(input logic [15:0] v);
        @(negedge clk); samp = v; samp_valid = 1'b1; reg_read = 1'b1;
        @(negedge clk); samp_valid = 1'b0; reg_read = 1'b0;
    endtask

    task automatic pulse_read();
        @(negedge clk); reg_read = 1'b1;
        @(negedge clk); reg_read = 1'b0;
    endtask

    task automatic pulse_sd();
        @(negedge clk); shutdown = 1'b1;
        idle(2);
        shutdown = 1'b0;
        idle(1);
    endtask

    initial begin
        #(20000 * 4);
        n_bad++;
        $display("FAIL watchdog expired in phase %s", phase);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        phase = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);
        expect_alarm(1'b0);

        // R3 / R8 / R9: comparator mode, depth 4, 12-bit resolution
        phase = "R3";
        queue_sel = 2'b10; res_sel = 2'd3;
        trip_lim = deg(50); hyst_lim = deg(45);
        idle(1);
        smp(deg(60), 3);
        phase = "R9";
        smp(deg(47), 1);                 // breaks the run
        idle(3);                         // no samples: nothing moves
        phase = "R8";
        smp(deg(60), 3);
        expect_alarm(1'b0);
        smp(deg(60), 1);
        expect_alarm(1'b1);
        phase = "R3";
        smp(deg(47), 2);
        smp(deg(40), 3);
        phase = "R9";
        smp(deg(45), 1);                 // equal to hysteresis: breaks run
        smp(deg(40), 3);
        expect_alarm(1'b1);
        phase = "R3";
        smp(deg(40), 1);
        expect_alarm(1'b0);

        // R4: read and shutdown leave the comparator alarm alone
        phase = "R4";
        smp(deg(60), 4);
        pulse_read();
        pulse_sd();
        expect_alarm(1'b1);
        smp(deg(40), 4);
        expect_alarm(1'b0);

        // R10: active-high polarity
        phase = "R10";
        pol_high = 1'b1;
        idle(2);
        smp(deg(60), 4);
        expect_alarm(1'b1);
        pol_high = 1'b0;
        idle(2);
        smp(deg(40), 4);

        // R2: truncation to the active resolution
        phase = "R2";
        queue_sel = 2'b00;
        trip_lim = deg(50) + 16'h0040;   // 50.25
        hyst_lim = deg(20);
        res_sel = 2'd0;
        idle(2);
        smp(deg(50) + 16'h0060, 1);      // 50.375: equal after 9-bit truncation
        expect_alarm(1'b0);
        res_sel = 2'd3;
        smp(deg(50) + 16'h0060, 1);
        expect_alarm(1'b1);
        hyst_lim = 16'hFAC0;             // -5.25
        res_sel = 2'd0;
        smp(16'hFAA0, 1);                // -5.375: both truncate to -5.5
        expect_alarm(1'b1);
        res_sel = 2'd3;
        smp(16'hFAA0, 1);
        expect_alarm(1'b0);

        // R11: depth change restarts the run, mode change clears
        phase = "R11";
        queue_sel = 2'b10;
        trip_lim = deg(50); hyst_lim = deg(45);
        idle(2);
        smp(deg(60), 3);
        queue_sel = 2'b01;
        idle(2);
        smp(deg(60), 1);
        expect_alarm(1'b0);
        smp(deg(60), 1);
        expect_alarm(1'b1);
        mode_intr = 1'b1;
        idle(2);
        expect_alarm(1'b0);

        // R5 / R6 / R7: interrupt mode, depth 2
        phase = "R5";
        smp(deg(60), 2);
        expect_alarm(1'b1);
        phase = "R6";
        pulse_read();
        expect_alarm(1'b0);
        phase = "R7";
        smp(deg(60), 2);
        expect_alarm(1'b0);
        smp(deg(40), 2);
        expect_alarm(1'b1);
        phase = "R6";
        pulse_sd();
        expect_alarm(1'b0);
        phase = "R7";
        smp(deg(40), 2);
        expect_alarm(1'b0);
        phase = "R6";
        smp(deg(60), 1);
        smp_rd(deg(60));                 // clear and set on the same edge
        expect_alarm(1'b1);
        pulse_read();
        expect_alarm(1'b0);

        // R8: depth 6 in comparator mode
        phase = "R8";
        mode_intr = 1'b0; queue_sel = 2'b11;
        idle(2);
        smp(deg(60), 5);
        expect_alarm(1'b0);
        smp(deg(60), 1);
        expect_alarm(1'b1);
        idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule